// File: doc/BRIEF.md
# Hot-Plug Slot Event Latch

This block watches the raw status lines of one hot-plug expansion slot and records each event of interest in a sticky bit that software clears by writing a one. It takes five sources:

- the attention button;
- the card retention latch sensor;
- the two card-presence lines;
- single-cycle fault pulses from the slot power controller, one for an isolated fault and one for a connected fault.

The level inputs cross into the block's clock through a two-flop synchronizer before their edges are judged. The fault pulses are taken as already synchronous.

A mask byte sits beside the event byte in the same 32-bit register word. It gates each latched event toward a level-sensitive interrupt request. It separately gates the connected-fault and sensor events toward a fatal-error request. That request also needs one of two external enables. Masks only shape the requests: they never stop an event bit from setting.

The register port is a plain control interface, not a stream. A write takes effect at the clock edge where `wr_en` is high, and there is no back-pressure. The read word is combinational from the held state.

Top module: `hp_slot_evt_latch`

## Requirements
- R1: After reset `rd_data` reads 32'h7F00_0000, and `irq` and `fatal_req` are low.
- R2: Bit 16 sets when either card-presence line changes value. A level change presented to the raw inputs before clock edge k is latched at edge k+2 and becomes readable after it. A level held steady through reset causes no event.
- R3: Bit 17 sets at any clock edge where `iso_fault_pulse` is high. Bit 20 sets at any edge where `conn_fault_pulse` is high.
- R4: Bit 18 sets only on a 0-to-1 change of the attention button. Release never sets it.
- R5: Bit 19 sets on every change of the latch sensor, rising or falling.
- R6: A write with `wr_be[2]` high clears each of bits 20:16 whose `wr_data` bit is 1. A zero data bit, or `wr_be[2]` low, leaves the bit unchanged.
- R7: Bits 31, 23:21 and 15:0 always read 0, and writes to them have no effect.
- R8: Bits 30:24 are read/write masks, written when `wr_be[3]` is high, each resetting to 1. Bits 24..28 are the interrupt masks for bits 16..20 in that order. Bit 29 masks the sensor event from the fatal request and bit 30 masks the connected fault from it.
- R9: `irq` is high exactly when some event bit 16+i is set while its interrupt mask bit 24+i is 0.
- R10: `fatal_req` is high exactly when (`serr_en` or `fatal_en`) holds and either bit 20 is set with bit 30 clear, or bit 19 is set with bit 29 clear.
- R11: When an event sets a bit in the same edge that a write clears it, the bit ends up set.
- R12: Mask values never change whether an event bit sets or clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| btn_raw | input | 1 | Attention button status, asynchronous |
| sns_raw | input | 1 | Retention latch sensor status, asynchronous |
| prsnt_raw | input | 2 | Card presence lines, asynchronous |
| iso_fault_pulse | input | 1 | Isolated power fault, one-cycle synchronous pulse |
| conn_fault_pulse | input | 1 | Connected power fault, one-cycle synchronous pulse |
| serr_en | input | 1 | System-error enable |
| fatal_en | input | 1 | Fatal-error reporting enable |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register read word |
| irq | output | 1 | Interrupt request level |
| fatal_req | output | 1 | Fatal-error request level |

## Verification
Random traffic toggles each raw line independently, with a bias toward holding still. This separates the rising-only button rule from the any-change rules of the sensor and presence lines, and exposes a wrong synchronizer depth as a one-cycle shift in when bits appear. Random writes pick their data and byte enables freely. This tells a correct write-one-to-clear apart from a plain overwrite or a byte-enable mix-up, and shows whether reserved positions stay zero. Directed cases cover:

- a card present through reset;
- a button release;
- a falling sensor;
- a fault pulse landing on its own clear;
- all masks set while events arrive.

The last case shows that the latch and the requests are kept apart.

// File: rtl/hp_evt_pkg.sv
package hp_evt_pkg;
  localparam int NUM_EV   = 5;
  localparam int EV_PRS   = 0;
  localparam int EV_IPF   = 1;
  localparam int EV_BTN   = 2;
  localparam int EV_SNS   = 3;
  localparam int EV_CPF   = 4;
  localparam int EV_LSB   = 16;
  localparam int MASK_LSB = 24;
  localparam int NUM_MASK = 7;
  localparam int MSK_SNS_ERR = 5;
  localparam int MSK_CPF_ERR = 6;
  localparam int NUM_RAW  = 4;
  localparam int RAW_PRS0 = 0;
  localparam int RAW_PRS1 = 1;
  localparam int RAW_BTN  = 2;
  localparam int RAW_SNS  = 3;
  typedef logic [NUM_EV-1:0]   ev_vec_t;
  typedef logic [NUM_MASK-1:0] mask_vec_t;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_i;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hp_evt_detect.sv
module hp_evt_detect
  import hp_evt_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_RAW-1:0] stat_s_i,
  input  logic               ipf_i,
  input  logic               cpf_i,
  output ev_vec_t            set_o
);
  localparam int ARM_CNT = STAGES + 1;
  localparam int CW      = $clog2(ARM_CNT + 1);

  logic [NUM_RAW-1:0] prev_q;
  logic [CW-1:0]      arm_cnt_q;
  logic               armed;
  logic [NUM_RAW-1:0] chg, rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      arm_cnt_q <= '0;
    end else begin
      prev_q <= stat_s_i;
      if (arm_cnt_q != CW'(ARM_CNT)) arm_cnt_q <= arm_cnt_q + 1'b1;
    end
  end

  assign armed = (arm_cnt_q == CW'(ARM_CNT));
  assign chg   = armed ? (stat_s_i ^ prev_q) : '0;
  assign rise  = armed ? (stat_s_i & ~prev_q) : '0;

  always_comb begin
    set_o         = '0;
    set_o[EV_PRS] = chg[RAW_PRS0] | chg[RAW_PRS1];
    set_o[EV_BTN] = rise[RAW_BTN];
    set_o[EV_SNS] = chg[RAW_SNS];
    set_o[EV_IPF] = ipf_i;
    set_o[EV_CPF] = cpf_i;
  end

  // R4
  btn_fall_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_q[RAW_BTN] && !stat_s_i[RAW_BTN]) |-> !set_o[EV_BTN]);

  // R2
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (set_o[EV_PRS] == 1'b0 && set_o[EV_SNS] == 1'b0));
endmodule

// File: rtl/hp_evt_latch.sv
module hp_evt_latch
  import hp_evt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ev_vec_t set_i,
  input  ev_vec_t clr_i,
  output ev_vec_t evt_o
);
  ev_vec_t evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_q & ~clr_i) | set_i;
  end

  assign evt_o = evt_q;

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & clr_i) != '0) |=> ((evt_o & $past(set_i & clr_i)) == $past(set_i & clr_i)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(evt_o));
endmodule

// File: rtl/hp_req_gate.sv
module hp_req_gate
  import hp_evt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ev_vec_t   evt_i,
  input  mask_vec_t mask_i,
  input  logic      serr_en_i,
  input  logic      fatal_en_i,
  output logic      irq_o,
  output logic      fatal_o
);
  ev_vec_t live;
  logic    err_src;

  assign live    = evt_i & ~mask_i[NUM_EV-1:0];
  assign irq_o   = |live;
  assign err_src = (evt_i[EV_CPF] & ~mask_i[MSK_CPF_ERR]) |
                   (evt_i[EV_SNS] & ~mask_i[MSK_SNS_ERR]);
  assign fatal_o = err_src & (serr_en_i | fatal_en_i);

  // R9
  irq_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (evt_i != '0));

  // R10
  fatal_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_o |-> (serr_en_i || fatal_en_i));
endmodule

// File: rtl/hp_slot_evt_latch.sv
module hp_slot_evt_latch
  import hp_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        btn_raw,
  input  logic        sns_raw,
  input  logic [1:0]  prsnt_raw,
  input  logic        iso_fault_pulse,
  input  logic        conn_fault_pulse,
  input  logic        serr_en,
  input  logic        fatal_en,
  input  logic        wr_en,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        irq,
  output logic        fatal_req
);
  localparam int EV_BYTE   = EV_LSB / 8;
  localparam int MASK_BYTE = MASK_LSB / 8;

  logic [NUM_RAW-1:0] raw_vec, stat_s;
  ev_vec_t            set_vec, clr_vec, evt;
  mask_vec_t          mask_q;

  always_comb begin
    raw_vec           = '0;
    raw_vec[RAW_PRS0] = prsnt_raw[0];
    raw_vec[RAW_PRS1] = prsnt_raw[1];
    raw_vec[RAW_BTN]  = btn_raw;
    raw_vec[RAW_SNS]  = sns_raw;
  end

  hp_sync #(.W(NUM_RAW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_vec), .q_o(stat_s));

  hp_evt_detect #(.STAGES(SYNC_STAGES)) u_det (
    .clk(clk), .rst_n(rst_n), .stat_s_i(stat_s),
    .ipf_i(iso_fault_pulse), .cpf_i(conn_fault_pulse), .set_o(set_vec));

  assign clr_vec = (wr_en && wr_be[EV_BYTE]) ? wr_data[EV_LSB +: NUM_EV] : '0;

  hp_evt_latch u_lat (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .evt_o(evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else if (wr_en && wr_be[MASK_BYTE]) mask_q <= wr_data[MASK_LSB +: NUM_MASK];
  end

  hp_req_gate u_gate (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .mask_i(mask_q),
    .serr_en_i(serr_en), .fatal_en_i(fatal_en), .irq_o(irq), .fatal_o(fatal_req));

  always_comb begin
    rd_data = '0;
    rd_data[EV_LSB +: NUM_EV]     = evt;
    rd_data[MASK_LSB +: NUM_MASK] = mask_q;
  end

  // R7
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31] == 1'b0 && rd_data[23:21] == 3'b0 && rd_data[15:0] == 16'h0));

  // R12
  mask_keeps_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[MASK_BYTE] && !wr_be[EV_BYTE]) |=>
      ((rd_data[20:16] & ~$past(rd_data[20:16])) == '0 || $past(set_vec) != '0));
endmodule

// File: tb/sim_hp_slot_evt_latch.sv
module sim_hp_slot_evt_latch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_raw = 0, sns_raw = 0;
  logic [1:0] prsnt_raw = 2'b01;
  logic iso_fault_pulse = 0, conn_fault_pulse = 0;
  logic serr_en = 0, fatal_en = 0;
  logic wr_en = 0;
  logic [3:0] wr_be = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic irq, fatal_req;

  always #10 clk = ~clk;

  hp_slot_evt_latch u0 (.*);

  int n_chk = 0, n_fail = 0;
  logic [4:0] evt_m = 0;
  logic [6:0] mask_m = 7'h7F;
  logic [3:0] h1, h2, h3;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return |(evt_m & ~mask_m[4:0]);
  endfunction

  function automatic logic exp_fatal();
    return (serr_en | fatal_en) &
           ((evt_m[4] & ~mask_m[6]) | (evt_m[3] & ~mask_m[5]));
  endfunction

  task automatic check_all();
    chk("R2 presence bit16", 32'(rd_data[16]), 32'(evt_m[0]));
    chk("R3 iso fault bit17", 32'(rd_data[17]), 32'(evt_m[1]));
    chk("R3 conn fault bit20", 32'(rd_data[20]), 32'(evt_m[4]));
    chk("R4 button bit18", 32'(rd_data[18]), 32'(evt_m[2]));
    chk("R5 sensor bit19", 32'(rd_data[19]), 32'(evt_m[3]));
    chk("R7 reserved", {rd_data[31], rd_data[23:21], rd_data[15:0]}, 32'h0);
    chk("R8 mask", 32'(rd_data[30:24]), 32'(mask_m));
    chk("R9 irq", 32'(irq), 32'(exp_irq()));
    chk("R10 fatal", 32'(fatal_req), 32'(exp_fatal()));
  endtask

  task automatic step(input logic [3:0] raw, input logic ipf, input logic cpf,
                      input logic we, input logic [3:0] be, input logic [31:0] wd);
    logic [4:0] setv, clrv;
    logic [3:0] chg;
    {sns_raw, btn_raw, prsnt_raw} = raw;
    iso_fault_pulse = ipf; conn_fault_pulse = cpf;
    wr_en = we; wr_be = be; wr_data = wd;
    chg = h2 ^ h3;
    setv = {cpf, chg[3], h2[2] & ~h3[2], ipf, chg[0] | chg[1]};
    clrv = (we && be[2]) ? wd[20:16] : 5'h0;
    evt_m = (evt_m & ~clrv) | setv;
    if (we && be[3]) mask_m = wd[30:24];
    h3 = h2; h2 = h1; h1 = raw;
    @(posedge clk); #1;
    wr_en = 0; iso_fault_pulse = 0; conn_fault_pulse = 0;
    @(negedge clk);
    check_all();
  endtask

  function automatic logic [3:0] cur_raw();
    return {sns_raw, btn_raw, prsnt_raw};
  endfunction

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] r;
    void'($urandom(32'd4242));
    h1 = 4'b0001; h2 = 4'b0001; h3 = 4'b0001;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 rd_data", rd_data, 32'h7F00_0000);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 fatal", 32'(fatal_req), 0);
    rst_n = 1'b1;
    // R2: presence held through reset, no event
    repeat (6) step(4'b0001, 0, 0, 0, 0, 0);
    // R4: press then release
    step(4'b0101, 0, 0, 0, 0, 0);
    repeat (4) step(4'b0101, 0, 0, 0, 0, 0);
    step(4'b0101, 0, 0, 1, 4'b0100, 32'h0004_0000);
    step(4'b0001, 0, 0, 0, 0, 0);
    repeat (4) step(4'b0001, 0, 0, 0, 0, 0);
    chk("R4 release no latch", 32'(rd_data[18]), 0);
    // R5: sensor rise and fall
    step(4'b1001, 0, 0, 0, 0, 0);
    repeat (3) step(4'b1001, 0, 0, 1, 4'b0100, 32'h0008_0000);
    step(4'b0001, 0, 0, 0, 0, 0);
    repeat (4) step(4'b0001, 0, 0, 0, 0, 0);
    chk("R5 fall latches", 32'(rd_data[19]), 1);
    // R10 with enables
    serr_en = 1;
    step(4'b0001, 0, 0, 1, 4'b1000, 32'h0000_0000);
    step(4'b0001, 0, 1, 0, 0, 0);
    chk("R10 fatal on cpf", 32'(fatal_req), 1);
    serr_en = 0; fatal_en = 1;
    step(4'b0001, 0, 0, 0, 0, 0);
    // R11: pulse with its own clear
    step(4'b0001, 0, 1, 1, 4'b0100, 32'h0010_0000);
    chk("R11 set wins", 32'(rd_data[20]), 1);
    // R6: clear and zero-write
    step(4'b0001, 0, 0, 1, 4'b0100, 32'h0000_0000);
    chk("R6 zero keeps", 32'(rd_data[20]), 1);
    step(4'b0001, 0, 0, 1, 4'b1011, 32'hFFFF_FFFF);
    chk("R6 be2 low keeps", 32'(rd_data[20]), 1);
    step(4'b0001, 0, 0, 1, 4'b0100, 32'h001F_0000);
    chk("R6 clear", 32'(rd_data[20:16]), 0);
    // R7: all-ones write
    step(4'b0001, 0, 0, 1, 4'b1111, 32'hFFE0_FFFF);
    // R12: all masked, events still latch
    step(4'b0001, 1, 1, 1, 4'b1000, 32'h7F00_0000);
    chk("R12 masked latch", 32'(rd_data[17]) & 32'(rd_data[20]), 1);
    chk("R12 irq low", 32'(irq), 0);
    fatal_en = 0;
    for (int i = 0; i < 3000; i++) begin
      r = cur_raw();
      for (int b = 0; b < 4; b++) if ($urandom_range(0, 5) == 0) r[b] = ~r[b];
      serr_en = ($urandom_range(0, 3) == 0);
      fatal_en = ($urandom_range(0, 3) == 0);
      step(r, $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
           $urandom_range(0, 3) == 0, 4'($urandom), $urandom);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule